// File: doc/BRIEF.md
# Debug Entry Cause and Return Offset Unit

This unit sits next to a processor's debug controller. When the core halts into debug state, it records what caused the halt. The cause is one of three: a breakpoint on an instruction fetch, a data watchpoint, or an external debug request. For a watchpoint, the unit also records whether it coincided with an exception. The cause is held as a two-bit code, made of a method flag and a break flag. The code stays valid until the debugger first touches the instruction-side scan chain.

While the core is halted, the unit counts the instructions the debugger runs, in two classes. `dbgInstr` pulses count instructions run at debug speed; this count includes the final return branch. `sysInstr` pulses count instructions run at system speed. From these counts and the recorded cause, the unit keeps a registered backward branch offset, in words. The debugger uses it to send the core back to the interrupted program address. System-speed instructions are weighted by three. The constant term is 4 for a plain breakpoint or watchpoint. It is 3 for an external request, or for a watchpoint that coincided with an exception.

A breakpoint and a prefetch abort can be raised by the same fetch. In that case the abort wins: no debug entry happens and an abort indication is raised. A later refetch of that address with the breakpoint still true enters debug state as normal.

Top module: `dbg_return_unit`

## Requirements
- R1: The cause code {methodFlag, breakFlag} is 2'b00 for a breakpoint, 2'b01 for a watchpoint and 2'b10 for an external request. The break flag is don't-care for an external request and is driven 0. When several entry strobes fall in one cycle, the priority is external request, then watchpoint, then breakpoint.
- R2: On entry the cause bits are captured and `causeHeld` rises the next cycle. The bits stay stable until the first `icAccess` after entry, and `causeHeld` falls in the cycle after that access. An `icAccess` in the entry cycle itself does not clear `causeHeld`.
- R3: After a breakpoint entry, or a watchpoint entry with `wpExc` low, `offset` equals 4 + N + 3*S.
- R4: After an external-request entry, or a watchpoint entry with `wpExc` high, `offset` equals 3 + N + 3*S.
- R5: N counts `dbgInstr` pulses and S counts `sysInstr` pulses. Pulses count only while `offsetValid` is high, and not in an entry cycle. Both classes may count in the same cycle. `offset` reflects a pulse in the cycle after it.
- R6: Both counts clear on every entry, so `offset` equals the base constant in the cycle after entry. The counts saturate at 2^CNT_W-1 (255 by default) instead of wrapping.
- R7: A `bkptHit` together with `pfAbort` causes no entry, and `abortTaken` is high in the next cycle. A watchpoint or external request in that same cycle still enters.
- R8: A later `bkptHit` with `pfAbort` low enters debug state with code 2'b00.
- R9: `offsetValid` rises in the cycle after the first entry and stays high. Before that, pulses leave `offset` at 0.
- R10: Synchronous active-low reset clears the cause bits, `causeHeld`, `abortTaken`, `offsetValid`, both counts and `offset`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| bkptHit | input | 1 | Breakpoint matched on an instruction fetch |
| wpHit | input | 1 | Watchpoint matched on a data access |
| wpExc | input | 1 | Watchpoint coincides with an exception (qualifies wpHit) |
| extReq | input | 1 | External debug request taken |
| pfAbort | input | 1 | Same fetch raised a prefetch abort |
| dbgInstr | input | 1 | One instruction executed at debug speed |
| sysInstr | input | 1 | One instruction executed at system speed |
| icAccess | input | 1 | Access to the instruction-side scan chain |
| methodFlag | output | 1 | Method-of-entry flag of the cause code |
| breakFlag | output | 1 | Break flag of the cause code |
| causeHeld | output | 1 | Cause bits are guaranteed valid |
| abortTaken | output | 1 | Prefetch abort overrode a breakpoint last cycle |
| offsetValid | output | 1 | Debug state has been entered |
| offset | output | OFF_W | Backward return branch offset in words |

## Verification
Two functions can meet in one cycle, and the bench provokes each pairing by driving both strobes on the same clock. The first pairing is a breakpoint with a prefetch abort, with and without a watchpoint alongside. It is judged by whether `offsetValid` and the cause code move and whether `abortTaken` rises. The second pairing is an entry strobe together with an instruction pulse or a scan-chain access. It is judged by `offset` holding the bare base constant and by `causeHeld` staying high.

// File: rtl/dbg_ret_pkg.sv
package dbg_ret_pkg;
  localparam int BASE_PLAIN = 4;
  localparam int BASE_LOW   = 3;

  typedef enum logic [1:0] {
    CAUSE_BKPT  = 2'b00,
    CAUSE_WATCH = 2'b01,
    CAUSE_EXT   = 2'b10
  } cause_e;

  typedef struct packed {
    logic enter;
    logic lowBase;
    logic countN;
    logic countS;
  } strobe_t;
endpackage

// File: rtl/dbg_ret_ctrl.sv
module dbg_ret_ctrl
  import dbg_ret_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bkptHit,
  input  logic    wpHit,
  input  logic    wpExc,
  input  logic    extReq,
  input  logic    pfAbort,
  input  logic    dbgInstr,
  input  logic    sysInstr,
  input  logic    icAccess,
  output strobe_t stb,
  output logic    methodFlag,
  output logic    breakFlag,
  output logic    causeHeld,
  output logic    inDebug,
  output logic    abortTaken
);
  logic   bkptTaken;
  cause_e causeNext;

  // abort outranks the breakpoint on the same fetch (R7)
  assign bkptTaken = bkptHit & ~pfAbort;

  always_comb begin
    if (extReq)     causeNext = CAUSE_EXT;
    else if (wpHit) causeNext = CAUSE_WATCH;
    else            causeNext = CAUSE_BKPT;
  end

  always_comb begin
    stb.enter   = extReq | wpHit | bkptTaken;
    stb.lowBase = extReq | (wpHit & wpExc);
    stb.countN  = inDebug & ~stb.enter & dbgInstr;
    stb.countS  = inDebug & ~stb.enter & sysInstr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      methodFlag <= 1'b0;
      breakFlag  <= 1'b0;
      causeHeld  <= 1'b0;
      inDebug    <= 1'b0;
      abortTaken <= 1'b0;
    end else begin
      abortTaken <= bkptHit & pfAbort;
      if (stb.enter) begin
        {methodFlag, breakFlag} <= causeNext;
        causeHeld <= 1'b1;
        inDebug   <= 1'b1;
      end else if (icAccess) begin
        causeHeld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbg_sat_counter.sv
module dbg_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cntNext
);
  localparam logic [W-1:0] MAXV = '1;
  logic [W-1:0] cnt;

  always_comb begin
    if (clr)                     cntNext = '0;
    else if (inc && cnt != MAXV) cntNext = cnt + 1'b1;
    else                         cntNext = cnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else       cnt <= cntNext;
  end
endmodule

// File: rtl/dbg_ret_datapath.sv
module dbg_ret_datapath
  import dbg_ret_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  output logic [OFF_W-1:0] offset
);
  localparam int NUM_CNT = 2;

  logic [NUM_CNT-1:0]   incVec;
  logic [CNT_W-1:0]     cntNext [NUM_CNT];
  logic                 lowReg;
  logic                 lowNext;
  logic [OFF_W-1:0]     baseVal;
  logic [OFF_W-1:0]     offsetNext;

  // index 0 = debug-speed count N, index 1 = system-speed count S
  assign incVec = {stb.countS, stb.countN};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    dbg_sat_counter #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rstN    (rstN),
      .clr     (stb.enter),
      .inc     (incVec[g]),
      .cntNext (cntNext[g])
    );
  end

  assign lowNext    = stb.enter ? stb.lowBase : lowReg;
  assign baseVal    = lowNext ? OFF_W'(BASE_LOW) : OFF_W'(BASE_PLAIN);
  assign offsetNext = baseVal + OFF_W'(cntNext[0]) + OFF_W'(cntNext[1]) * OFF_W'(3);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowReg <= 1'b0;
      offset <= '0;
    end else begin
      lowReg <= lowNext;
      if (stb.enter || stb.countN || stb.countS) offset <= offsetNext;
    end
  end
endmodule

// File: rtl/dbg_return_unit.sv
module dbg_return_unit
  import dbg_ret_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bkptHit,
  input  logic             wpHit,
  input  logic             wpExc,
  input  logic             extReq,
  input  logic             pfAbort,
  input  logic             dbgInstr,
  input  logic             sysInstr,
  input  logic             icAccess,
  output logic             methodFlag,
  output logic             breakFlag,
  output logic             causeHeld,
  output logic             abortTaken,
  output logic             offsetValid,
  output logic [OFF_W-1:0] offset
);
  strobe_t stb;

  dbg_ret_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bkptHit    (bkptHit),
    .wpHit      (wpHit),
    .wpExc      (wpExc),
    .extReq     (extReq),
    .pfAbort    (pfAbort),
    .dbgInstr   (dbgInstr),
    .sysInstr   (sysInstr),
    .icAccess   (icAccess),
    .stb        (stb),
    .methodFlag (methodFlag),
    .breakFlag  (breakFlag),
    .causeHeld  (causeHeld),
    .inDebug    (offsetValid),
    .abortTaken (abortTaken)
  );

  dbg_ret_datapath #(.CNT_W(CNT_W), .OFF_W(OFF_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .offset (offset)
  );
endmodule

// File: rtl/dbg_return_chk.sv
module dbg_return_chk #(
  parameter int OFF_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             bkptHit,
  input logic             wpHit,
  input logic             wpExc,
  input logic             extReq,
  input logic             pfAbort,
  input logic             dbgInstr,
  input logic             sysInstr,
  input logic             icAccess,
  input logic             methodFlag,
  input logic             breakFlag,
  input logic             causeHeld,
  input logic             abortTaken,
  input logic             offsetValid,
  input logic [OFF_W-1:0] offset
);
  logic anyEntry;
  logic lowB;
  assign anyEntry = extReq || wpHit || (bkptHit && !pfAbort);
  assign lowB     = extReq || (wpHit && wpExc);

  p_ext_code_r1: assert property (@(posedge clk) disable iff (!rstN)
    extReq |=> (methodFlag && !breakFlag && causeHeld));

  p_cause_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (causeHeld && !icAccess && !anyEntry) |=>
      ($stable(methodFlag) && $stable(breakFlag) && causeHeld));

  p_held_drop_r2: assert property (@(posedge clk) disable iff (!rstN)
    (icAccess && !anyEntry) |=> !causeHeld);

  // base constant after entry: R3 / R4 / R6
  p_entry_base_r4: assert property (@(posedge clk) disable iff (!rstN)
    anyEntry |=> (offset == ($past(lowB) ? OFF_W'(3) : OFF_W'(4))));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!anyEntry && !dbgInstr && !sysInstr) |=> $stable(offset));

  p_abort_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bkptHit && pfAbort) |=> abortTaken);

  p_abort_noentry_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bkptHit && pfAbort && !wpHit && !extReq && !offsetValid) |=> !offsetValid);

  p_valid_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    offsetValid |=> offsetValid);

  p_reset_r10: assert property (@(posedge clk)
    !rstN |=> (!offsetValid && !causeHeld && !abortTaken && offset == '0));
endmodule

bind dbg_return_unit dbg_return_chk #(.OFF_W(OFF_W)) u_chk (.*);

// File: tb/tb_dbg_return_unit.sv
module tb_dbg_return_unit;
  localparam int CLK_PERIOD = 10;
  localparam int OFF_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bkptHit = 0, wpHit = 0, wpExc = 0, extReq = 0, pfAbort = 0;
  logic dbgInstr = 0, sysInstr = 0, icAccess = 0;
  logic methodFlag, breakFlag, causeHeld, abortTaken, offsetValid;
  logic [OFF_W-1:0] offset;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_return_unit #(.CNT_W(8), .OFF_W(OFF_W)) dut (.*);

  // kind: 0 breakpoint, 1 watchpoint, 2 external request, 3 watchpoint with exception
  typedef struct packed {
    logic [1:0]  kind;
    logic [8:0]  nDbg;
    logic [8:0]  nSys;
    logic [15:0] expOff;
    logic [1:0]  expCode;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{kind: 2'd0, nDbg: 9'd1, nSys: 9'd0, expOff: 16'd5,  expCode: 2'b00},
    '{kind: 2'd1, nDbg: 9'd2, nSys: 9'd1, expOff: 16'd9,  expCode: 2'b01},
    '{kind: 2'd2, nDbg: 9'd1, nSys: 9'd2, expOff: 16'd10, expCode: 2'b10},
    '{kind: 2'd3, nDbg: 9'd3, nSys: 9'd0, expOff: 16'd6,  expCode: 2'b01},
    '{kind: 2'd0, nDbg: 9'd0, nSys: 9'd0, expOff: 16'd4,  expCode: 2'b00},
    '{kind: 2'd2, nDbg: 9'd4, nSys: 9'd4, expOff: 16'd19, expCode: 2'b10}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic enter(int kind);
    bkptHit = (kind == 0);
    wpHit   = (kind == 1) || (kind == 3);
    wpExc   = (kind == 3);
    extReq  = (kind == 2);
    tick();
    bkptHit = 0; wpHit = 0; wpExc = 0; extReq = 0;
  endtask

  task automatic pulses(int nd, int ns);
    for (int i = 0; i < nd; i++) begin dbgInstr = 1; tick(); end
    dbgInstr = 0;
    for (int i = 0; i < ns; i++) begin sysInstr = 1; tick(); end
    sysInstr = 0;
  endtask

  task automatic doReset();
    rstN = 0; tick(); tick(); rstN = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #2;
    doReset();
    chk("R10 reset valid", int'(offsetValid), 0);
    chk("R10 reset offset", int'(offset), 0);
    chk("R10 reset held", int'(causeHeld), 0);

    // R9: pulses before any entry do nothing
    pulses(3, 2);
    chk("R9 no count before entry", int'(offset), 0);
    chk("R9 not valid before entry", int'(offsetValid), 0);

    // vector table: R1 R3 R4 R5 R6
    foreach (VECS[k]) begin
      enter(int'(VECS[k].kind));
      chk("R6 base after entry", int'(offset), (VECS[k].kind >= 2) ? 3 : 4);
      chk("R1 cause code", int'({methodFlag, breakFlag}), int'(VECS[k].expCode));
      chk("R9 valid", int'(offsetValid), 1);
      pulses(int'(VECS[k].nDbg), int'(VECS[k].nSys));
      chk((VECS[k].kind >= 2) ? "R4 offset" : "R3 offset", int'(offset), int'(VECS[k].expOff));
    end

    // R5: both classes in one cycle
    enter(0);
    dbgInstr = 1; sysInstr = 1; tick(); tick(); dbgInstr = 0; sysInstr = 0;
    chk("R5 dual pulse", int'(offset), 4 + 2 + 6);

    // R5/R6: pulse in entry cycle ignored
    extReq = 1; dbgInstr = 1; sysInstr = 1; tick();
    extReq = 0; dbgInstr = 0; sysInstr = 0;
    chk("R5 entry cycle pulse ignored", int'(offset), 3);

    // R6 saturation
    enter(0);
    pulses(300, 0);
    chk("R6 N saturates", int'(offset), 4 + 255);
    pulses(0, 300);
    chk("R6 S saturates", int'(offset), 4 + 255 + 765);

    // R2 hold and drop
    enter(1);
    chk("R2 held", int'(causeHeld), 1);
    pulses(2, 0);
    chk("R2 still held", int'(causeHeld), 1);
    chk("R2 code stable", int'({methodFlag, breakFlag}), 2'b01);
    icAccess = 1; tick(); icAccess = 0;
    chk("R2 drop after access", int'(causeHeld), 0);
    wpHit = 1; icAccess = 1; tick(); wpHit = 0; icAccess = 0;
    chk("R2 access in entry cycle", int'(causeHeld), 1);

    // R1 priority
    extReq = 1; wpHit = 1; bkptHit = 1; tick();
    extReq = 0; wpHit = 0; bkptHit = 0;
    chk("R1 ext priority", int'({methodFlag, breakFlag}), 2'b10);
    wpHit = 1; bkptHit = 1; tick(); wpHit = 0; bkptHit = 0;
    chk("R1 watch over bkpt", int'({methodFlag, breakFlag}), 2'b01);

    // R7 abort beats breakpoint from a fresh reset
    doReset();
    bkptHit = 1; pfAbort = 1; tick(); bkptHit = 0; pfAbort = 0;
    chk("R7 abort taken", int'(abortTaken), 1);
    chk("R7 no entry", int'(offsetValid), 0);
    chk("R7 held low", int'(causeHeld), 0);
    tick();
    chk("R7 abort pulse ends", int'(abortTaken), 0);
    // R8 refetch enters
    enter(0);
    chk("R8 refetch enters", int'(offsetValid), 1);
    chk("R8 code", int'({methodFlag, breakFlag}), 2'b00);
    chk("R8 offset", int'(offset), 4);
    // R7 with watchpoint in same cycle
    doReset();
    bkptHit = 1; pfAbort = 1; wpHit = 1; tick();
    bkptHit = 0; pfAbort = 0; wpHit = 0;
    chk("R7 watch still enters", int'(offsetValid), 1);
    chk("R7 watch code", int'({methodFlag, breakFlag}), 2'b01);
    chk("R7 abort with watch", int'(abortTaken), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule